// File: doc/BRIEF.md
# Audio Sample Memory Streaming Controller

This block sits between a stereo codec serial interface and a word-wide memory port. Each frame strobe from the codec side marks a new captured stereo pair. The controller stores the pair in two consecutive memory words at a record address. It then fetches the next playback pair from two consecutive words at a separate playback address, and presents that pair on its outputs so the codec interface can pick it up at the following strobe.

A session starts when the run input rises. The two base addresses and a frame limit are applied at that moment. The session ends when the limit is reached or when run is taken low. The memory side uses a plain request/acknowledge handshake: one access per request, with a write enable that selects the direction. The memory clock is far faster than the audio frame rate, so a burst normally completes well before the next strobe. A strobe that arrives while a burst is still in progress is flagged.

Top module: `audio_mem_streamer`

## Requirements
- R1: After reset, mem_req_o, done_o and overrun_o are 0, and out_left_o and out_right_o are 0.
- R2: A strobe accepted while waiting causes two writes, in this order. The first stores the left capture word at the record pointer. The second stores the right capture word at record pointer + 1. Both have mem_we_o = 1.
- R3: After both writes have been acknowledged, the block issues two reads with mem_we_o = 0. The first is at the playback pointer and the second at playback pointer + 1.
- R4: mem_req_o stays high from the cycle it is raised until the cycle in which mem_ack_i is sampled high. Address, write enable and write data do not change while the request waits.
- R5: After each completed frame, the record pointer and the playback pointer each advance by 2. Both wrap modulo 2^ADDR_W.
- R6: When run_i rises in the idle or done state, the pointers load rec_base_i and play_base_i. The same edge clears the frame count, done_o and overrun_o.
- R7: out_left_o and out_right_o take the two read words together, in the cycle after the second read is acknowledged. At all other times they hold their values.
- R8: done_o rises when the number of completed frames equals a nonzero frame_limit_i. A frame_limit_i of 0 means there is no limit.
- R9: If run_i is low while the block waits for a strobe, it goes to done. If run_i falls during a burst, the burst completes and the block then goes to done.
- R10: While idle or done, strobes cause no memory access. done_o stays high until run_i rises again.
- R11: A strobe sampled during a burst sets overrun_o. overrun_o then stays high until the next run start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Session enable; its rising edge starts a session |
| frame_stb_i | input | 1 | One-cycle frame strobe from the codec interface |
| rec_base_i | input | ADDR_W | Start address for recorded samples |
| play_base_i | input | ADDR_W | Start address for playback samples |
| frame_limit_i | input | CNT_W | Number of frames per session, 0 = unlimited |
| cap_left_i | input | DATA_W | Captured left sample |
| cap_right_i | input | DATA_W | Captured right sample |
| out_left_o | output | DATA_W | Playback left sample |
| out_right_o | output | DATA_W | Playback right sample |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle per access |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ack_i |
| done_o | output | 1 | Session finished |
| overrun_o | output | 1 | Sticky: a strobe arrived during a burst |

## Verification
The bench varies the memory latency and runs sessions against a frame limit, with no limit, and with run dropped both while waiting and in the middle of a burst. A design that stopped one frame early or late on the limit would show done_o at the wrong cycle. A design that aborted a burst on run low would show missing handshakes. The record base is placed just below the top of the address space, so a pointer that failed to wrap would issue a wrong address. Strobes are also sent during bursts, during idle and after done. A controller that started a stray burst, or that lost or cleared the overrun flag too early, is caught by the handshake and flag comparison made on every clock.

// File: rtl/ams_pkg.sv
package ams_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_WR_L, ST_WR_R, ST_RD_L, ST_RD_R, ST_DONE
  } ams_state_e;
endpackage

// File: rtl/ams_ptr.sv
module ams_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (load_i)  ptr_o <= base_i;
    else if (step_i)  ptr_o <= ptr_o + STEP;
  end

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> ptr_o == ADDR_W'($past(ptr_o) + STEP));
endmodule

// File: rtl/ams_xfer_cnt.sv
module ams_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (inc_i)    cnt_q <= cnt_q + ONE;
  end

  // next completion reaches the limit; limit 0 never ends the run
  assign last_o = (limit_i != '0) && (cnt_q == limit_i - ONE);
endmodule

// File: rtl/ams_fsm.sv
module ams_fsm
  import ams_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       stb_i,
  input  logic       ack_i,
  input  logic       last_i,
  output ams_state_e state_o,
  output logic       start_o,
  output logic       accept_o,
  output logic       frame_end_o
);
  ams_state_e state_d;
  logic       run_q;

  assign start_o     = ((state_o == ST_IDLE) || (state_o == ST_DONE)) && run_i && !run_q;
  assign accept_o    = (state_o == ST_WAIT) && run_i && stb_i;
  assign frame_end_o = (state_o == ST_RD_R) && ack_i;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE, ST_DONE: if (start_o) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!run_i)     state_d = ST_DONE;
        else if (stb_i) state_d = ST_WR_L;
      end
      ST_WR_L: if (ack_i) state_d = ST_WR_R;
      ST_WR_R: if (ack_i) state_d = ST_RD_L;
      ST_RD_L: if (ack_i) state_d = ST_RD_R;
      ST_RD_R: if (ack_i) state_d = (last_i || !run_i) ? ST_DONE : ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_o <= state_d;
      run_q   <= run_i;
    end
  end

  // R2
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WR_L) && ack_i |=> state_o == ST_WR_R);
  // R3
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WR_R) && ack_i |=> state_o == ST_RD_L);
  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DONE) && !(run_i && !run_q) |=> state_o == ST_DONE);
endmodule

// File: rtl/audio_mem_streamer.sv
module audio_mem_streamer
  import ams_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              frame_stb_i,
  input  logic [ADDR_W-1:0] rec_base_i,
  input  logic [ADDR_W-1:0] play_base_i,
  input  logic [CNT_W-1:0]  frame_limit_i,
  input  logic [DATA_W-1:0] cap_left_i,
  input  logic [DATA_W-1:0] cap_right_i,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              overrun_o
);
  localparam logic [ADDR_W-1:0] NEXT = ADDR_W'(1);

  ams_state_e        state;
  logic              start, accept, frame_end, last, in_burst;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [DATA_W-1:0] cap_l_q, cap_r_q, rd_l_q;

  ams_fsm u_fsm (
    .clk_i, .rst_ni, .run_i,
    .stb_i       (frame_stb_i),
    .ack_i       (mem_ack_i),
    .last_i      (last),
    .state_o     (state),
    .start_o     (start),
    .accept_o    (accept),
    .frame_end_o (frame_end)
  );

  ams_ptr #(.ADDR_W(ADDR_W)) u_rec_ptr (
    .clk_i, .rst_ni,
    .load_i (start), .base_i (rec_base_i),
    .step_i ((state == ST_WR_R) && mem_ack_i),
    .ptr_o  (wptr)
  );

  ams_ptr #(.ADDR_W(ADDR_W)) u_play_ptr (
    .clk_i, .rst_ni,
    .load_i (start), .base_i (play_base_i),
    .step_i (frame_end),
    .ptr_o  (rptr)
  );

  ams_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clear_i (start), .inc_i (frame_end),
    .limit_i (frame_limit_i),
    .last_o  (last)
  );

  assign in_burst = (state == ST_WR_L) || (state == ST_WR_R) ||
                    (state == ST_RD_L) || (state == ST_RD_R);

  always_comb begin
    mem_req_o   = in_burst;
    mem_we_o    = (state == ST_WR_L) || (state == ST_WR_R);
    mem_wdata_o = (state == ST_WR_R) ? cap_r_q : cap_l_q;
    unique case (state)
      ST_WR_L: mem_addr_o = wptr;
      ST_WR_R: mem_addr_o = wptr + NEXT;
      ST_RD_L: mem_addr_o = rptr;
      ST_RD_R: mem_addr_o = rptr + NEXT;
      default: mem_addr_o = '0;
    endcase
  end

  assign done_o = (state == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_l_q     <= '0;
      cap_r_q     <= '0;
      rd_l_q      <= '0;
      out_left_o  <= '0;
      out_right_o <= '0;
      overrun_o   <= 1'b0;
    end else begin
      if (accept) begin
        cap_l_q <= cap_left_i;
        cap_r_q <= cap_right_i;
      end
      if ((state == ST_RD_L) && mem_ack_i) rd_l_q <= mem_rdata_i;
      if (frame_end) begin
        out_left_o  <= rd_l_q;
        out_right_o <= mem_rdata_i;
      end
      if (start)                         overrun_o <= 1'b0;
      else if (frame_stb_i && in_burst)  overrun_o <= 1'b1;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));
  // R7
  out_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(out_left_o) && $stable(out_right_o));
  // R11
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !start |=> overrun_o);
  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && frame_stb_i |=> !mem_req_o);
endmodule

// File: tb/audio_mem_streamer_tb_top.sv
module audio_mem_streamer_tb_top;
  localparam int AW = 16, DW = 20, CW = 16;
  localparam int M_IDLE = 0, M_WAIT = 1, M_BURST = 2, M_DONE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, stb = 1'b0, ack = 1'b0;
  logic [AW-1:0] rec_base = '0, play_base = '0;
  logic [CW-1:0] limit = '0;
  logic [DW-1:0] cap_l = '0, cap_r = '0, rdata = '0;
  logic [DW-1:0] out_l, out_r, wdata;
  logic req, we, done, ovr;
  logic [AW-1:0] addr;

  always #2.5 clk = ~clk;

  audio_mem_streamer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .frame_stb_i(stb),
    .rec_base_i(rec_base), .play_base_i(play_base), .frame_limit_i(limit),
    .cap_left_i(cap_l), .cap_right_i(cap_r),
    .out_left_o(out_l), .out_right_o(out_r),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .done_o(done), .overrun_o(ovr));

  int n_run = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // values seen at the last rising edge
  logic s_run, s_stb, s_req, s_ack, s_we;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wd, s_cl, s_cr;
  always @(posedge clk) begin
    s_run <= run; s_stb <= stb; s_req <= req; s_ack <= ack; s_we <= we;
    s_addr <= addr; s_wd <= wdata; s_cl <= cap_l; s_cr <= cap_r;
  end

  logic [DW-1:0] bmem [0:4095];
  int lat = 0, wcnt = 0;

  // reference model
  int m = M_IDLE, phase = 0, cnt = 0;
  bit m_prev_run = 0, m_done = 0, m_ovr = 0;
  int wp = 0, rp = 0;
  int m_ol = 0, m_or = 0, rd0 = 0;
  int q_we[$], q_addr[$], q_wd[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      m = M_IDLE; m_prev_run = 0; m_done = 0; m_ovr = 0; m_ol = 0; m_or = 0;
      ack = 1'b0; wcnt = 0;
      q_we.delete(); q_addr.delete(); q_wd.delete();
    end else begin
      bit start;
      start = (m == M_IDLE || m == M_DONE) && s_run && !m_prev_run;
      case (m)
        M_IDLE, M_DONE: if (start) begin
          m = M_WAIT; wp = int'(rec_base); rp = int'(play_base);
          cnt = 0; m_done = 0; m_ovr = 0;
        end
        M_WAIT: begin
          if (!s_run) begin m = M_DONE; m_done = 1; end
          else if (s_stb) begin
            q_we.push_back(1); q_addr.push_back(wp);               q_wd.push_back(int'(s_cl));
            q_we.push_back(1); q_addr.push_back((wp + 1) & 16'hFFFF); q_wd.push_back(int'(s_cr));
            q_we.push_back(0); q_addr.push_back(rp);               q_wd.push_back(0);
            q_we.push_back(0); q_addr.push_back((rp + 1) & 16'hFFFF); q_wd.push_back(0);
            m = M_BURST; phase = 0;
          end
        end
        M_BURST: begin
          if (s_stb) m_ovr = 1;
          if (s_req && s_ack) begin
            int ewe, ea, ed;
            ewe = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_wd.pop_front();
            chk(int'(s_we) == ewe, ewe ? "R2 write enable" : "R3 read enable", int'(s_we), ewe);
            chk(int'(s_addr) == ea, ewe ? "R2 R5 write address" : "R3 R5 read address", int'(s_addr), ea);
            if (ewe != 0) chk(int'(s_wd) == ed, "R2 write data", int'(s_wd), ed);
            if (phase == 2) rd0 = int'(bmem[ea[11:0]]);
            if (phase == 3) begin
              m_ol = rd0; m_or = int'(bmem[ea[11:0]]);
              wp = (wp + 2) & 16'hFFFF; rp = (rp + 2) & 16'hFFFF; cnt++;
              if ((limit != 0 && cnt == int'(limit)) || !s_run) begin
                m = M_DONE; m_done = 1;
              end else m = M_WAIT;
            end
            phase++;
          end
        end
        default: m = M_IDLE;
      endcase
      m_prev_run = s_run;

      chk(req == (m == M_BURST), "R4 R10 request level", int'(req), int'(m == M_BURST));
      chk(int'(out_l) == m_ol && int'(out_r) == m_or, "R7 output pair",
          int'(out_l), m_ol);
      chk(done == m_done, "R8 done flag", int'(done), int'(m_done));
      chk(ovr == m_ovr, "R11 overrun flag", int'(ovr), int'(m_ovr));

      // memory responder
      if (ack) begin
        ack = 1'b0; wcnt = 0;
      end else if (req) begin
        if (wcnt >= lat) begin
          ack = 1'b1;
          if (we) bmem[addr[11:0]] = wdata;
          else    rdata = bmem[addr[11:0]];
        end else wcnt++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int l, input int r, input int gap);
    @(negedge clk);
    cap_l = DW'(l); cap_r = DW'(r); stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    cyc(gap);
  endtask

  task automatic start_run(input int rb, input int pb, input int lim);
    @(negedge clk);
    rec_base = AW'(rb); play_base = AW'(pb); limit = CW'(lim); run = 1'b1;
    cyc(2);
    chk(done == 1'b0 && ovr == 1'b0, "R6 flags cleared at start", int'({done, ovr}), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = DW'(i * 37 + 5);
    cyc(3);
    chk(req == 0 && done == 0 && ovr == 0, "R1 reset flags", int'({req, done, ovr}), 0);
    chk(out_l == 0 && out_r == 0, "R1 reset outputs", int'(out_l), 0);
    rst_n = 1'b1;
    cyc(2);

    // strobe while idle
    frame(32'h11, 32'h22, 4);
    chk(req == 0 && done == 0, "R10 idle strobe ignored", int'(req), 0);

    // limited session
    lat = 2;
    start_run(32'h100, 32'h200, 3);
    for (int f = 0; f < 3; f++) frame(32'hA000 + f, 32'hB000 + f, 40);
    chk(done == 1, "R8 done after limit", int'(done), 1);
    chk(bmem[12'h104] == DW'(32'hA002) && bmem[12'h105] == DW'(32'hB002),
        "R2 R5 third pair stored", int'(bmem[12'h104]), 32'hA002);
    frame(32'h33, 32'h44, 6);
    chk(req == 0 && done == 1, "R10 strobe after done ignored", int'(req), 0);

    // unlimited, record base wraps, run dropped while waiting
    @(negedge clk); run = 1'b0;
    cyc(2);
    lat = 0;
    start_run(32'hFFFF, 32'h300, 0);
    for (int f = 0; f < 4; f++) frame(32'hC000 + f, 32'hD000 + f, 30);
    chk(done == 0, "R8 limit zero keeps running", int'(done), 0);
    chk(bmem[12'hFFF] == DW'(32'hC000) && bmem[12'h000] == DW'(32'hD000),
        "R5 wrap store", int'(bmem[12'h000]), 32'hD000);
    @(negedge clk); run = 1'b0;
    cyc(3);
    chk(done == 1, "R9 run low while waiting", int'(done), 1);

    // overrun and run drop during a burst
    lat = 6;
    start_run(32'h400, 32'h500, 0);
    frame(32'hE000, 32'hF000, 0);
    frame(32'hE001, 32'hF001, 3);
    chk(ovr == 1, "R11 overrun set", int'(ovr), 1);
    cyc(60);
    chk(ovr == 1, "R11 overrun sticky", int'(ovr), 1);
    frame(32'hE002, 32'hF002, 0);
    @(negedge clk); run = 1'b0;
    cyc(60);
    chk(done == 1 && bmem[12'h403] == DW'(32'hF002), "R9 burst completes after run drop",
        int'(bmem[12'h403]), 32'hF002);

    // restart clears overrun and reloads pointers
    lat = 1;
    start_run(32'h600, 32'h700, 1);
    frame(32'h1234, 32'h5678, 40);
    chk(bmem[12'h600] == DW'(32'h1234), "R6 pointer reloaded", int'(bmem[12'h600]), 32'h1234);
    chk(done == 1, "R8 single frame limit", int'(done), 1);

    cyc(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule